// File: doc/BRIEF.md
# Vector load/store address generator

This block sits between instruction decode and the load/store pipe of a core that moves data between memory and its vector/floating-point register file. Each strobed 32-bit instruction word is classified as a post-indexed, pre-indexed or scaled unsigned-offset register transfer. The block derives the transfer size and direction and picks out the data register index. It combines the supplied 64-bit base value (a general register, or the stack pointer when the base field is 31) with the decoded immediate to produce the memory address and, for the indexed classes, the updated base value to be written back.

Malformed words are reported rather than executed. A word that fits none of the three classes raises a not-recognised flag. A word whose scale exceeds the largest transfer raises an undefined flag. A misaligned stack-pointer base raises an alignment fault. In every one of these cases the access and writeback enables stay low. All results appear on registered outputs one clock after the input strobe.

Top module: `vls_agen`

## Requirements
- R1: A word is recognised only when bits 29:27 are 111 and bit 26 is 1, and either (bits 25:24 = 00, bit 21 = 0 and bits 11:10 = 01 for post-index or 11 for pre-index) or bits 25:24 = 01 (unsigned offset). Any other word sets unrec_flag and holds acc_en and wb_en low.
- R2: The scale is the 3-bit value {bit 23, bits 31:30}. A recognised word with scale above 4 sets undef_flag and holds acc_en and wb_en low.
- R3: For an accepted word, acc_bytes equals 1 shifted left by the scale (1, 2, 4, 8 or 16).
- R4: is_load follows bit 22: 1 means load, 0 means store.
- R5: In both indexed classes the byte offset is bits 20:12 sign-extended, giving -256 to 255 with no scaling, and the address arithmetic wraps modulo 2^64.
- R6: In the unsigned-offset class the offset is bits 21:10 zero-extended and shifted left by the scale, the address is base plus offset, and wb_en stays low.
- R7: Post-index accesses memory at the unmodified base, and it drives wb_val = base + offset with wb_en high.
- R8: Pre-index accesses memory at base + offset, and it drives wb_val with that same sum and wb_en high.
- R9: When bits 9:5 equal 31 and the base value is not a multiple of 16, sp_fault is set and both acc_en and wb_en stay low. With any other base index, base alignment has no effect.
- R10: rt_idx carries bits 4:0 of the accepted word.
- R11: Every output reflects the word strobed one clock earlier. out_valid, the enables and the flags are low in cycles without a strobe and after reset. The payload outputs (eff_addr, wb_val, acc_bytes, is_load, rt_idx) hold their values until the next strobe.
- R12: At most one of unrec_flag, undef_flag and sp_fault is set. Not-recognised takes precedence over undefined, and undefined over the alignment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: insn and base_val are valid |
| insn | input | 32 | Instruction word |
| base_val | input | ADDR_W | Value of the selected base register or stack pointer |
| out_valid | output | 1 | Results of the previous strobe are present |
| acc_en | output | 1 | Memory access may proceed |
| is_load | output | 1 | 1 = load, 0 = store |
| acc_bytes | output | MAX_SCALE+1 | Transfer size in bytes |
| rt_idx | output | 5 | Data register index |
| eff_addr | output | ADDR_W | Memory address of the access |
| wb_en | output | 1 | Write wb_val back to the base register |
| wb_val | output | ADDR_W | Updated base value |
| undef_flag | output | 1 | Scale out of range |
| unrec_flag | output | 1 | Word matches no class |
| sp_fault | output | 1 | Misaligned stack-pointer base |

## Verification
A wrong class or scale decode shows up on the very next clock edge after the strobe. It can appear as an enable in the wrong state, as a flag on a legal word, or as an address that has been offset when it should not be, or offset by the wrong scale. The bench sweeps all size and opcode combinations in every class against sign-boundary immediates and wrapping bases. It also covers every value of the class-selecting bit groups, so any single mis-decoded bit changes a compared output within one cycle. Idle cycles after strobes show whether the enables leak without a strobe or the payload fails to hold.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int INSN_W  = 32;
  localparam int IDX_W   = 5;
  localparam int SCALE_W = 3;
  localparam int IMMS_W  = 9;
  localparam int IMMU_W  = 12;
  localparam logic [IDX_W-1:0] SP_INDEX = 5'd31;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_POST = 2'd1,
    CLS_PRE  = 2'd2,
    CLS_UOFF = 2'd3
  } cls_e;

  typedef struct packed {
    cls_e               cls;
    logic [SCALE_W-1:0] scale;
    logic               is_load;
    logic [IDX_W-1:0]   rt;
    logic               base_is_sp;
    logic [IMMS_W-1:0]  imm_s;
    logic [IMMU_W-1:0]  imm_u;
  } dec_t;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic fam_ok;
  logic idx_ok;
  logic uoff_ok;

  always_comb begin
    fam_ok  = (insn[29:27] == 3'b111) && insn[26];
    idx_ok  = fam_ok && (insn[25:24] == 2'b00) && !insn[21] && insn[10];
    uoff_ok = fam_ok && (insn[25:24] == 2'b01);

    if (uoff_ok)
      dec.cls = CLS_UOFF;
    else if (idx_ok && insn[11])
      dec.cls = CLS_PRE;
    else if (idx_ok)
      dec.cls = CLS_POST;
    else
      dec.cls = CLS_NONE;

    dec.scale      = {insn[23], insn[31:30]};
    dec.is_load    = insn[22];
    dec.rt         = insn[4:0];
    dec.base_is_sp = (insn[9:5] == SP_INDEX);
    dec.imm_s      = insn[20:12];
    dec.imm_u      = insn[21:10];
  end
endmodule

// File: rtl/vls_addr.sv
module vls_addr
  import vls_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] upd_base,
  output logic              sp_misaligned
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    if (dec.cls == CLS_UOFF)
      offset = {{(ADDR_W-IMMU_W){1'b0}}, dec.imm_u} << dec.scale;
    else
      offset = {{(ADDR_W-IMMS_W){dec.imm_s[IMMS_W-1]}}, dec.imm_s};

    sum      = base_val + offset;
    upd_base = sum;
    eff_addr = (dec.cls == CLS_POST) ? base_val : sum;

    sp_misaligned = dec.base_is_sp && (base_val[SP_ALIGN_LOG2-1:0] != '0);
  end
endmodule

// File: rtl/vls_agen.sv
module vls_agen
  import vls_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_LOG2 = 4,
  parameter int MAX_SCALE     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [31:0]          insn,
  input  logic [ADDR_W-1:0]    base_val,
  output logic                 out_valid,
  output logic                 acc_en,
  output logic                 is_load,
  output logic [MAX_SCALE:0]   acc_bytes,
  output logic [4:0]           rt_idx,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic                 wb_en,
  output logic [ADDR_W-1:0]    wb_val,
  output logic                 undef_flag,
  output logic                 unrec_flag,
  output logic                 sp_fault
);
  localparam int BYTES_W = MAX_SCALE + 1;

  dec_t              dec;
  logic [ADDR_W-1:0] addr_c;
  logic [ADDR_W-1:0] upd_c;
  logic              misal_c;

  vls_decode u_decode (
    .insn (insn),
    .dec  (dec)
  );

  vls_addr #(
    .ADDR_W        (ADDR_W),
    .SP_ALIGN_LOG2 (SP_ALIGN_LOG2)
  ) u_addr (
    .dec           (dec),
    .base_val      (base_val),
    .eff_addr      (addr_c),
    .upd_base      (upd_c),
    .sp_misaligned (misal_c)
  );

  // next-state signals
  logic               recog_c, undef_c, fault_c, good_c;
  logic               valid_n, acc_en_n, wb_en_n, undef_n, unrec_n, fault_n;
  logic [BYTES_W-1:0] bytes_c;

  always_comb begin
    recog_c = (dec.cls != CLS_NONE);
    undef_c = recog_c && (int'(dec.scale) > MAX_SCALE);
    fault_c = recog_c && !undef_c && misal_c;
    good_c  = recog_c && !undef_c && !fault_c;

    if (int'(dec.scale) <= MAX_SCALE)
      bytes_c = {{(BYTES_W-1){1'b0}}, 1'b1} << dec.scale;
    else
      bytes_c = '0;

    valid_n  = in_valid;
    acc_en_n = in_valid && good_c;
    wb_en_n  = in_valid && good_c && (dec.cls != CLS_UOFF);
    unrec_n  = in_valid && !recog_c;
    undef_n  = in_valid && undef_c;
    fault_n  = in_valid && fault_c;
  end

  // control registers: updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      acc_en     <= 1'b0;
      wb_en      <= 1'b0;
      unrec_flag <= 1'b0;
      undef_flag <= 1'b0;
      sp_fault   <= 1'b0;
    end else begin
      out_valid  <= valid_n;
      acc_en     <= acc_en_n;
      wb_en      <= wb_en_n;
      unrec_flag <= unrec_n;
      undef_flag <= undef_n;
      sp_fault   <= fault_n;
    end
  end

  // payload registers: clock enable on the input strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_addr  <= '0;
      wb_val    <= '0;
      acc_bytes <= '0;
      is_load   <= 1'b0;
      rt_idx    <= '0;
    end else if (in_valid) begin
      eff_addr  <= addr_c;
      wb_val    <= upd_c;
      acc_bytes <= bytes_c;
      is_load   <= dec.is_load;
      rt_idx    <= dec.rt;
    end
  end
endmodule

// File: rtl/vls_agen_chk.sv
module vls_agen_chk #(
  parameter int ADDR_W    = 64,
  parameter int MAX_SCALE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic               acc_en,
  input logic [MAX_SCALE:0] acc_bytes,
  input logic [ADDR_W-1:0]  eff_addr,
  input logic               wb_en,
  input logic               undef_flag,
  input logic               unrec_flag,
  input logic               sp_fault
);
  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R11

  AST_NO_STROBE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R11

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(acc_en || wb_en || undef_flag || unrec_flag || sp_fault));  // R11

  AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(eff_addr));  // R11

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_flag, unrec_flag, sp_fault}));  // R12

  AST_FLAG_BLOCKS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_flag || unrec_flag || sp_fault) |-> !(acc_en || wb_en));  // R9

  AST_WB_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> acc_en);  // R7

  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> ($countones(acc_bytes) == 1));  // R3
endmodule

bind vls_agen vls_agen_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_SCALE (MAX_SCALE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .acc_en     (acc_en),
  .acc_bytes  (acc_bytes),
  .eff_addr   (eff_addr),
  .wb_en      (wb_en),
  .undef_flag (undef_flag),
  .unrec_flag (unrec_flag),
  .sp_fault   (sp_fault)
);

// File: tb/vls_agen_bench.sv
module vls_agen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn;
  logic [63:0] base_val;
  logic        out_valid, acc_en, is_load, wb_en, undef_flag, unrec_flag, sp_fault;
  logic [4:0]  acc_bytes;
  logic [4:0]  rt_idx;
  logic [63:0] eff_addr, wb_val;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vls_agen u_vls_agen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .base_val(base_val),
    .out_valid(out_valid), .acc_en(acc_en), .is_load(is_load), .acc_bytes(acc_bytes),
    .rt_idx(rt_idx), .eff_addr(eff_addr), .wb_en(wb_en), .wb_val(wb_val),
    .undef_flag(undef_flag), .unrec_flag(unrec_flag), .sp_fault(sp_fault)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected values, computed from the requirements
  task automatic apply_and_check(input logic [31:0] w, input logic [63:0] b);
    logic       fam, idx, post, pre, uoff, rec, und, flt, good;
    logic [2:0] sc;
    logic [63:0] off, sum, exp_addr;
    string tag;
    fam  = (w[29:27] == 3'b111) && w[26];
    idx  = fam && (w[25:24] == 2'b00) && !w[21] && w[10];
    post = idx && !w[11];
    pre  = idx && w[11];
    uoff = fam && (w[25:24] == 2'b01);
    rec  = post || pre || uoff;
    sc   = {w[23], w[31:30]};
    und  = rec && (sc > 3'd4);
    flt  = rec && !und && (w[9:5] == 5'd31) && (b[3:0] != 4'd0);
    good = rec && !und && !flt;
    off  = uoff ? ({52'd0, w[21:10]} << sc) : {{55{w[20]}}, w[20:12]};
    sum  = b + off;
    exp_addr = post ? b : sum;
    tag  = post ? "R7" : (pre ? "R8" : "R6");

    insn     = w;
    base_val = b;
    in_valid = 1'b1;
    @(negedge clk);
    check("R11", "out_valid", 64'(out_valid), 64'd1);
    check("R1",  "unrec_flag", 64'(unrec_flag), 64'(!rec));
    check("R2",  "undef_flag", 64'(undef_flag), 64'(und));
    check("R9",  "sp_fault", 64'(sp_fault), 64'(flt));
    check("R12", "flag count", 64'($countones({unrec_flag, undef_flag, sp_fault})),
          64'($countones({!rec, und, flt})));
    check(rec ? tag : "R1", "acc_en", 64'(acc_en), 64'(good));
    check(rec ? tag : "R1", "wb_en", 64'(wb_en), 64'(good && !uoff));
    if (good) begin
      check("R3",  "acc_bytes", 64'(acc_bytes), 64'd1 << sc);
      check("R4",  "is_load", 64'(is_load), 64'(w[22]));
      check("R10", "rt_idx", 64'(rt_idx), 64'(w[4:0]));
      check(tag,   "eff_addr", eff_addr, exp_addr);
      if (!uoff) check("R5", "wb_val", wb_val, sum);
    end
  endtask

  task automatic idle_check();
    logic [63:0] held;
    held     = eff_addr;
    in_valid = 1'b0;
    insn     = 32'hFFFF_FFFF;
    base_val = ~base_val;
    @(negedge clk);
    check("R11", "idle out_valid", 64'(out_valid), 64'd0);
    check("R11", "idle enables", 64'({acc_en, wb_en, unrec_flag, undef_flag, sp_fault}), 64'd0);
    check("R11", "idle eff_addr hold", eff_addr, held);
  endtask

  function automatic logic [31:0] mk(input int cls, input logic [1:0] sz, input logic [1:0] opc,
                                     input logic [11:0] imm, input logic [4:0] rn,
                                     input logic [4:0] rt);
    if (cls == 2) return {sz, 3'b111, 1'b1, 2'b01, opc, imm, rn, rt};
    return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm[8:0], (cls == 1) ? 2'b11 : 2'b01, rn, rt};
  endfunction

  initial begin
    int cyc;
    for (cyc = 0; cyc < 200000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] bases [3];
    logic [11:0] imms  [4];
    bases[0] = 64'h0000_0000_0000_1000;
    bases[1] = 64'hFFFF_FFFF_FFFF_FFF8;
    bases[2] = 64'h0000_0000_0000_0004;
    in_valid = 1'b0;
    insn     = '0;
    base_val = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "reset out_valid", 64'(out_valid), 64'd0);
    check("R11", "reset enables", 64'({acc_en, wb_en, unrec_flag, undef_flag, sp_fault}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int cls = 0; cls < 3; cls++) begin
      if (cls == 2) begin
        imms[0] = 12'h000; imms[1] = 12'h001; imms[2] = 12'hFFF; imms[3] = 12'h800;
      end else begin
        imms[0] = 12'h000; imms[1] = 12'h0FF; imms[2] = 12'h100; imms[3] = 12'h1FF;
      end
      for (int sz = 0; sz < 4; sz++)
        for (int opc = 0; opc < 4; opc++)
          for (int k = 0; k < 4; k++)
            for (int r = 0; r < 2; r++)
              for (int bi = 0; bi < 3; bi++) begin
                apply_and_check(mk(cls, 2'(sz), 2'(opc), imms[k], r ? 5'd31 : 5'd5,
                                   5'(sz * 8 + opc + k)), bases[bi]);
                if (bi == 2 && k == 3) idle_check();
              end
    end

    // sweep of every class-selecting bit group (R1)
    for (int top = 0; top < 16; top++)
      for (int g = 0; g < 4; g++)
        for (int b21 = 0; b21 < 2; b21++)
          for (int lo = 0; lo < 4; lo++)
            apply_and_check({2'b10, 4'(top), 2'(g), 2'b01, 1'(b21), 9'h1F0, 2'(lo),
                             5'd31, 5'd9}, 64'h0000_0000_0000_2000);
    idle_check();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule